// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block moves a data word between two buses, A and B, in either direction. Each direction has its own storage register. The A-side register captures the A bus on a rising edge of its capture strobe. The B-side register captures the B bus on a rising edge of its own strobe. Each output side carries one of two values, chosen by a select input: the live word from the opposite bus, or the word held in the opposite side's register. Every bus is split into three ports: an input, an output and an output enable. The tri-state pad sits outside the block, which also lets the bus input see the block's own driven value when a side is enabled.

Two generic control inputs, `ctl_p` and `ctl_q`, set which side drives. Their meaning depends on the `DUAL_EN` parameter.

- **Dual-enable style** (`DUAL_EN=1`): `ctl_p` high enables the B outputs. `ctl_q` low enables the A outputs. Both sides may drive together.
- **Single-enable style** (`DUAL_EN=0`): `ctl_p` is an active-low enable and `ctl_q` picks the direction. This style never drives both sides.

`INVERT` picks inverting or non-inverting outputs. The strobes are plain inputs sampled in the system clock domain. The output multiplexer and enables are registered, so switching a select cannot glitch a bus.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, both output enables are 0 and both storage registers hold zero. A stored-path read after reset returns all zeros when `INVERT=0` and all ones when `INVERT=1`.
- R2: At the clock edge where `cap_ab` is sampled 1 after being 0 on the previous edge, the A register loads `a_in`. `cap_ba` loads `b_in` into the B register in the same way.
- R3: Capture happens whatever the output enables and selects are.
- R4: With `sel_ab`=0, `b_out` carries the live `a_in`. With `sel_ab`=1, it carries the A register. `sel_ba` chooses `a_out` from `b_in` or the B register in the same way.
- R5: In the dual-enable style, `b_oe` follows `ctl_p` and `a_oe` follows the inverse of `ctl_q`. With `ctl_p`=0 and `ctl_q`=1, both buses are isolated.
- R6: In the dual-enable style, `ctl_p`=1, `ctl_q`=0 and both selects at 1 drive the A register onto B and the B register onto A in the same cycle.
- R7: When B is driven with live A data and `b_in` sees that driven word, a `cap_ba` edge copies the A data into the B register.
- R8: In the single-enable style, `ctl_p`=1 isolates both buses. With `ctl_p`=0, `ctl_q`=1 drives B only and `ctl_q`=0 drives A only. `a_oe` and `b_oe` are never both 1.
- R9: With `INVERT=1`, every driven output word is the bitwise complement of the selected data. With `INVERT=0`, it is the selected data unchanged.
- R10: Output data and enables change only at a clock edge, exactly one edge after the inputs that select them.
- R11: A strobe held high loads its register once. Later changes of the bus while the strobe stays high do not reach the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Value seen on bus A |
| a_out | output | WIDTH | Word driven toward bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | WIDTH | Value seen on bus B |
| b_out | output | WIDTH | Word driven toward bus B |
| b_oe | output | 1 | Drive enable for bus B |
| cap_ab | input | 1 | Capture strobe for the A register (rising edge) |
| cap_ba | input | 1 | Capture strobe for the B register (rising edge) |
| sel_ab | input | 1 | B-side source: 0 live A, 1 A register |
| sel_ba | input | 1 | A-side source: 0 live B, 1 B register |
| ctl_p | input | 1 | Dual style: B enable, active high. Single style: enable, active low |
| ctl_q | input | 1 | Dual style: A enable, active low. Single style: direction, 1 drives B |

## Verification
A register load takes effect at the same edge where the strobe is first seen high. A live word reaches the opposite output one edge after it is presented. A newly captured word therefore shows on a stored-path output one edge after its load, which is two edges after the strobe rose.

The bench changes inputs one nanosecond after a rising edge and reads outputs one nanosecond after the following edge. It also reads once more before that edge, to confirm that nothing moved early. Register contents are observed only through a stored-path read at the outputs, and each scenario waits the exact number of edges this pipeline needs.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  typedef struct packed {
    logic ab;  // drive bus B from the A path
    logic ba;  // drive bus A from the B path
  } drive_t;

  // Decode the two generic control pins for either control style.
  function automatic drive_t fn_drive(input bit dual, input logic p, input logic q);
    drive_t d;
    if (dual) begin
      d.ab = p;
      d.ba = ~q;
    end else begin
      d.ab = ~p & q;
      d.ba = ~p & ~q;
    end
    return d;
  endfunction

  // 0-to-1 change between the previous and the current sample.
  function automatic logic fn_rise(input logic prev, input logic cur);
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/regbus_edge.sv
module regbus_edge
  import regbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= strobe;
  end

  assign rise = fn_rise(prev_q, strobe);

  // R11
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/regbus_store.sv
module regbus_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d)));

  // R11
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/regbus_outpath.sv
module regbus_outpath #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  input  logic             sel,
  input  logic             en,
  output logic [WIDTH-1:0] dout,
  output logic             oe
);
  logic [WIDTH-1:0] pick;
  logic [WIDTH-1:0] shaped;

  assign pick = sel ? stored : live;

  generate
    if (INVERT) begin : g_inv
      assign shaped = ~pick;
    end else begin : g_pass
      assign shaped = pick;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      oe   <= 1'b0;
    end else begin
      dout <= shaped;
      oe   <= en;
    end
  end

  // R10
  oe_latency_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> oe);

  // R10
  oe_off_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !oe);
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit DUAL_EN = 1'b1,
  parameter bit INVERT  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             cap_ab,
  input  logic             cap_ba,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             ctl_p,
  input  logic             ctl_q
);
  localparam logic [WIDTH-1:0] RST_VIEW = INVERT ? {WIDTH{1'b1}} : '0;

  logic             rise_ab, rise_ba;
  logic [WIDTH-1:0] reg_a, reg_b;
  drive_t           drv;

  assign drv = fn_drive(DUAL_EN, ctl_p, ctl_q);

  regbus_edge u_edge_ab (.clk(clk), .rst(rst), .strobe(cap_ab), .rise(rise_ab));
  regbus_edge u_edge_ba (.clk(clk), .rst(rst), .strobe(cap_ba), .rise(rise_ba));

  regbus_store #(.WIDTH(WIDTH)) u_store_a (
    .clk(clk), .rst(rst), .load(rise_ab), .d(a_in), .q(reg_a));
  regbus_store #(.WIDTH(WIDTH)) u_store_b (
    .clk(clk), .rst(rst), .load(rise_ba), .d(b_in), .q(reg_b));

  regbus_outpath #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_b (
    .clk(clk), .rst(rst), .live(a_in), .stored(reg_a), .sel(sel_ab),
    .en(drv.ab), .dout(b_out), .oe(b_oe));
  regbus_outpath #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_a (
    .clk(clk), .rst(rst), .live(b_in), .stored(reg_b), .sel(sel_ba),
    .en(drv.ba), .dout(a_out), .oe(a_oe));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!a_oe && !b_oe && reg_a == '0 && reg_b == '0));

  // R9
  live_ab_polarity_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_ab |=> (b_out == (INVERT ? ~$past(a_in) : $past(a_in))));

  // R9
  stored_ba_view_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_ba && reg_b == '0) |=> (a_out == RST_VIEW));

  generate
    if (!DUAL_EN) begin : g_single_chk
      // R8
      one_side_chk: assert property (@(posedge clk) disable iff (rst)
        !(a_oe && b_oe));
    end else begin : g_dual_chk
      // R5
      dual_b_en_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_p |=> b_oe);
    end
  endgenerate
endmodule

// File: tb/regbus_xcvr_bench.sv
module regbus_xcvr_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic rst;

  // dual-enable, non-inverting instance
  logic [7:0] d_a_ext, d_b_ext, d_a_in, d_b_in, d_a_out, d_b_out;
  logic d_a_oe, d_b_oe, d_cap_ab, d_cap_ba, d_sel_ab, d_sel_ba, d_p, d_q;
  // single-enable, inverting instance
  logic [7:0] s_a_ext, s_b_ext, s_a_in, s_b_in, s_a_out, s_b_out;
  logic s_a_oe, s_b_oe, s_cap_ab, s_cap_ba, s_sel_ab, s_sel_ba, s_p, s_q;

  // Loop a driven side back onto its own input, as the bus pad would.
  assign d_a_in = d_a_oe ? d_a_out : d_a_ext;
  assign d_b_in = d_b_oe ? d_b_out : d_b_ext;
  assign s_a_in = s_a_oe ? s_a_out : s_a_ext;
  assign s_b_in = s_b_oe ? s_b_out : s_b_ext;

  regbus_xcvr #(.WIDTH(8), .DUAL_EN(1'b1), .INVERT(1'b0)) u_regbus_xcvr (
    .clk(clk), .rst(rst), .a_in(d_a_in), .a_out(d_a_out), .a_oe(d_a_oe),
    .b_in(d_b_in), .b_out(d_b_out), .b_oe(d_b_oe), .cap_ab(d_cap_ab),
    .cap_ba(d_cap_ba), .sel_ab(d_sel_ab), .sel_ba(d_sel_ba),
    .ctl_p(d_p), .ctl_q(d_q));

  regbus_xcvr #(.WIDTH(8), .DUAL_EN(1'b0), .INVERT(1'b1)) u_regbus_xcvr_single (
    .clk(clk), .rst(rst), .a_in(s_a_in), .a_out(s_a_out), .a_oe(s_a_oe),
    .b_in(s_b_in), .b_out(s_b_out), .b_oe(s_b_oe), .cap_ab(s_cap_ab),
    .cap_ba(s_cap_ba), .sel_ab(s_sel_ab), .sel_ba(s_sel_ba),
    .ctl_p(s_p), .ctl_q(s_q));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    d_p = 1'b0; d_q = 1'b1; s_p = 1'b1; s_q = 1'b0;
    d_cap_ab = 0; d_cap_ba = 0; d_sel_ab = 0; d_sel_ba = 0;
    s_cap_ab = 0; s_cap_ba = 0; s_sel_ab = 0; s_sel_ba = 0;
    d_a_ext = 8'h00; d_b_ext = 8'h00; s_a_ext = 8'h00; s_b_ext = 8'h00;
    repeat (3) tick();
    chk("R1 dual enables in reset", {6'd0, d_a_oe, d_b_oe}, 8'h00);
    chk("R1 single enables in reset", {6'd0, s_a_oe, s_b_oe}, 8'h00);
    rst = 1'b0;
    d_sel_ab = 1; d_p = 1;
    s_sel_ab = 1; s_p = 0; s_q = 1;
    tick();
    chk("R1 dual stored A after reset", d_b_out, 8'h00);
    chk("R1 single stored A after reset inverted", s_b_out, 8'hFF);
    d_p = 0; d_sel_ab = 0; s_p = 1; s_sel_ab = 0;
    tick();
  endtask

  task automatic t_store_isolated();
    d_p = 0; d_q = 1;
    d_a_ext = 8'h3C; d_b_ext = 8'hA5; d_cap_ab = 1; d_cap_ba = 1;
    tick();
    d_cap_ab = 0; d_cap_ba = 0; d_a_ext = 8'h00; d_b_ext = 8'hFF;
    tick();
    chk("R5 isolation enables", {6'd0, d_a_oe, d_b_oe}, 8'h00);
    d_sel_ab = 1; d_sel_ba = 1; d_p = 1; d_q = 0;
    tick();
    chk("R6 stored A on B", d_b_out, 8'h3C);
    chk("R6 stored B on A", d_a_out, 8'hA5);
    chk("R5 both enabled", {6'd0, d_a_oe, d_b_oe}, 8'h03);
    chk("R3 capture while isolated", d_b_out ^ d_a_out, 8'h3C ^ 8'hA5);
    d_p = 0; d_q = 1; d_sel_ab = 0; d_sel_ba = 0;
    tick();
  endtask

  task automatic t_realtime();
    d_p = 1; d_q = 1; d_sel_ab = 0; d_a_ext = 8'h5A;
    tick();
    chk("R4 live A on B", d_b_out, 8'h5A);
    chk("R5 A side off", {7'd0, d_a_oe}, 8'h00);
    d_a_ext = 8'hC3;
    #2;
    chk("R10 output held before edge", d_b_out, 8'h5A);
    tick();
    chk("R10 output after one edge", d_b_out, 8'hC3);
    d_p = 0;
    tick();
  endtask

  task automatic t_hold_strobe();
    d_p = 0; d_q = 1; d_a_ext = 8'h11; d_cap_ab = 1;
    tick();
    d_a_ext = 8'h22;
    tick();
    tick();
    d_cap_ab = 0;
    d_p = 1; d_sel_ab = 1;
    tick();
    chk("R11 held strobe loads once", d_b_out, 8'h11);
    d_p = 0; d_sel_ab = 0;
    tick();
  endtask

  task automatic t_copy();
    d_p = 1; d_q = 1; d_sel_ab = 0; d_a_ext = 8'h77; d_b_ext = 8'h00;
    tick();
    chk("R7 B driven with live A", d_b_in, 8'h77);
    d_cap_ba = 1;
    tick();
    d_cap_ba = 0; d_p = 0; d_q = 0; d_sel_ba = 1;
    tick();
    chk("R7 B register holds copied A", d_a_out, 8'h77);
    d_q = 1; d_sel_ba = 0;
    tick();
  endtask

  task automatic t_single();
    chk("R8 single isolated", {6'd0, s_a_oe, s_b_oe}, 8'h00);
    s_a_ext = 8'h0F; s_cap_ab = 1;
    tick();
    s_cap_ab = 0; s_p = 0; s_q = 1; s_sel_ab = 1;
    tick();
    chk("R9 inverted stored A on B", s_b_out, 8'hF0);
    chk("R8 dir high drives B only", {6'd0, s_a_oe, s_b_oe}, 8'h01);
    s_p = 1;
    tick();
    s_p = 0; s_q = 0; s_sel_ba = 0; s_b_ext = 8'h33;
    tick();
    chk("R9 inverted live B on A", s_a_out, 8'hCC);
    chk("R8 dir low drives A only", {6'd0, s_a_oe, s_b_oe}, 8'h02);
    s_b_ext = 8'h81;
    tick();
    chk("R4 live B follows on A", s_a_out, 8'h7E);
    s_p = 1;
    tick();
    chk("R8 enable high isolates", {6'd0, s_a_oe, s_b_oe}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_store_isolated();
    t_realtime();
    t_hold_strobe();
    t_copy();
    t_single();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule